// File: doc/BRIEF.md
# Serial-in latched switch control register

This block is the digital control core of an eight-channel switch driver. A host shifts a control word in one bit per rising clock edge. The shift register feeds a bank of transparent latches, and each latch drives one switch-enable line. While the active-low load input is low, the switch lines follow the shift register. While it is high, they hold the value captured when it rose.

The last shift stage is also driven onto a serial output. Several blocks can therefore be chained, the serial output of one feeding the serial input of the next, all sharing the clock. An active-high clear empties the shift register and the latches at once and overrides every other input.

Top module: `sw_serial_latch`

## Requirements
- R1: On every rising edge of `clk` with `clear` low, stage n+1 takes the old value of stage n, and stage 0 takes `ser_in`.
- R2: `sw_on[k]` is driven from latch k, which is loaded from shift stage k. A value of 1 means switch k is ON and 0 means OFF. A word shifted MSB first therefore ends with its MSB on `sw_on[7]` after eight clocks.
- R3: While `load_n` is low and `clear` is low, `sw_on` equals the shift register contents and tracks each shift.
- R4: The latches capture the shift register contents when `load_n` rises. While `load_n` stays high, clocking and `ser_in` leave `sw_on` unchanged.
- R5: While `clear` is high, the shift register and all latches are zero, without waiting for a clock edge, whatever the state of `load_n`, `clk` and `ser_in`.
- R6: `ser_out` equals the last shift stage (stage 7). A bit entered at one edge appears on `ser_out` after the eighth edge, counting that edge as the first.
- R7: After `clear` falls, the first rising clock edge shifts `ser_in` into stage 0 of an all-zero register.
- R8: `ser_out` changes only on a rising clock edge or on `clear`. Toggling `load_n` or `ser_in` between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| clear | input | 1 | Asynchronous clear, active high, highest priority |
| ser_in | input | 1 | Serial data into stage 0 |
| load_n | input | 1 | Latch control: low = transparent, high = hold |
| sw_on | output | 8 | Switch enables, 1 = ON |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
Two pairs of functions can fall in the same cycle. The first is a clear and a shift edge: `clear` is raised between edges, while the register holds ones and the latches are transparent, and then held across a rising edge with `ser_in` high. It is judged by zero switch lines and a zero serial output both before and after that edge. The second is a latch capture and continued shifting: `load_n` rises at a point where the register holds a known word, and eight more clocks follow. The frozen outputs are compared with that word, and the shifted contents are compared once `load_n` falls again.

// File: rtl/sw_ctrl_pkg.sv
`timescale 1ns/1ps
package sw_ctrl_pkg;
  // number of switch channels per block
  localparam int unsigned SW_COUNT = 8;
  typedef logic [SW_COUNT-1:0] sw_word_t;
endpackage

// File: rtl/sw_shift_chain.sv
`timescale 1ns/1ps
module sw_shift_chain #(
  parameter int unsigned N = sw_ctrl_pkg::SW_COUNT
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         ser_in,
  output logic [N-1:0] stages
);
  logic [N-1:0] stages_d;

  // next state: stage n+1 takes stage n, stage 0 takes the serial input
  always_comb begin
    stages_d = {stages[N-2:0], ser_in};
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) stages <= '0;
    else       stages <= stages_d;
  end

  // R1: serial input lands in stage 0 on the edge
  a_r1_enter_stage0: assert property (@(posedge clk) disable iff (clear)
    1'b1 |=> stages[0] == $past(ser_in));

  // R7: first edge after clear release starts from an empty register
  a_r7_resume_empty: assert property (@(posedge clk) disable iff (clear)
    $past(clear) |-> stages == '0);
endmodule

// File: rtl/sw_latch_bank.sv
`timescale 1ns/1ps
module sw_latch_bank #(
  parameter int unsigned N = sw_ctrl_pkg::SW_COUNT
) (
  input  logic         clear,
  input  logic         load_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;
    // level-sensitive storage: clear wins, transparent while load_n low
    always_latch begin
      if (clear)        bit_q <= 1'b0;
      else if (!load_n) bit_q <= d[k];
    end
    assign q[k] = bit_q;
  end
endmodule

// File: rtl/sw_serial_latch.sv
`timescale 1ns/1ps
module sw_serial_latch #(
  parameter int unsigned N = sw_ctrl_pkg::SW_COUNT
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         ser_in,
  input  logic         load_n,
  output logic [N-1:0] sw_on,
  output logic         ser_out
);
  logic [N-1:0] sr_q;

  sw_shift_chain #(.N(N)) u_chain (
    .clk    (clk),
    .clear  (clear),
    .ser_in (ser_in),
    .stages (sr_q)
  );

  sw_latch_bank #(.N(N)) u_latch (
    .clear  (clear),
    .load_n (load_n),
    .d      (sr_q),
    .q      (sw_on)
  );

  assign ser_out = sr_q[N-1];

  // R3: transparent latches mirror the shift register
  a_r3_follow: assert property (@(posedge clk) disable iff (clear)
    !load_n |-> sw_on == sr_q);

  // R4: held outputs do not move while load_n stays high
  a_r4_hold: assert property (@(posedge clk) disable iff (clear)
    (load_n && $past(load_n)) |-> $stable(sw_on));

  // R5: clear empties the latches and the chain output
  a_r5_clear: assert property (@(posedge clk)
    clear |-> (sw_on == '0 && !ser_out));

  // R6: serial output is the word shifted one stage past stage N-2
  a_r6_ser_out: assert property (@(posedge clk) disable iff (clear)
    1'b1 |=> ser_out == $past(sr_q[N-2]));
endmodule

// File: tb/test_sw_serial_latch.sv
`timescale 1ns/1ps
module test_sw_serial_latch;
  logic       clk = 1'b0;
  logic       clear;
  logic       ser_in;
  logic       load_n;
  logic [7:0] sw_on;
  logic       ser_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [7:0] m_sr;
  logic [7:0] m_lat;

  always #2 clk = ~clk;

  sw_serial_latch i_sw_serial_latch (
    .clk(clk), .clear(clear), .ser_in(ser_in), .load_n(load_n),
    .sw_on(sw_on), .ser_out(ser_out)
  );

  // stimulus vectors {clear, load_n, ser_in}
  localparam logic [2:0] VEC [24] = '{
    3'b100, 3'b001, 3'b000, 3'b001, 3'b001, 3'b000, 3'b000, 3'b001,
    3'b000, 3'b011, 3'b011, 3'b010, 3'b011, 3'b001, 3'b110, 3'b111,
    3'b001, 3'b001, 3'b000, 3'b011, 3'b010, 3'b001, 3'b101, 3'b000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic d);
    string rq;
    @(negedge clk);
    clear = c; load_n = l; ser_in = d;
    if (c) begin m_sr = '0; m_lat = '0; end
    else if (!l) m_lat = m_sr;
    rq = c ? "R5" : (l ? "R4" : "R3");
    #1;
    chk(rq, sw_on, m_lat);
    chk("R6", {7'd0, ser_out}, {7'd0, m_sr[7]});
    @(posedge clk);
    if (c) m_sr = '0; else m_sr = {m_sr[6:0], d};
    if (c) m_lat = '0; else if (!l) m_lat = m_sr;
    #1;
    chk(c ? "R5" : "R1", sw_on, m_lat);
    chk("R6", {7'd0, ser_out}, {7'd0, m_sr[7]});
  endtask

  task automatic shift_word(input logic [7:0] w, input logic l);
    for (int b = 7; b >= 0; b--) step(1'b0, l, w[b]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] held;
    clear = 1'b1; load_n = 1'b1; ser_in = 1'b0;
    m_sr = '0; m_lat = '0;
    #1;
    chk("R5", sw_on, 8'h00);
    chk("R5", {7'd0, ser_out}, 8'h00);

    for (int i = 0; i < 24; i++) step(VEC[i][2], VEC[i][1], VEC[i][0]);

    // R2: MSB first lands on switch 7
    step(1'b1, 1'b0, 1'b0);
    shift_word(8'hC3, 1'b0);
    chk("R2", sw_on, 8'hC3);
    // R1: one more shift moves every bit up one stage
    step(1'b0, 1'b0, 1'b0);
    chk("R1", sw_on, 8'h86);

    // R6: a single one reaches the serial output on the eighth edge
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
    chk("R6", {7'd0, ser_out}, 8'h00);
    step(1'b0, 1'b1, 1'b0);
    chk("R6", {7'd0, ser_out}, 8'h01);

    // R4: capture on load_n rise, then shift ones underneath
    step(1'b1, 1'b0, 1'b0);
    shift_word(8'h5A, 1'b0);
    shift_word(8'hFF, 1'b1);
    chk("R4", sw_on, 8'h5A);
    step(1'b0, 1'b0, 1'b1);
    chk("R3", sw_on, 8'hFF);

    // R5: clear between edges acts at once, then wins over an edge
    @(negedge clk);
    clear = 1'b1; ser_in = 1'b1; load_n = 1'b0;
    #1;
    chk("R5", sw_on, 8'h00);
    chk("R5", {7'd0, ser_out}, 8'h00);
    @(posedge clk); #1;
    chk("R5", sw_on, 8'h00);
    m_sr = '0; m_lat = '0;

    // R7: first edge after release shifts into an empty register
    @(negedge clk);
    clear = 1'b0; ser_in = 1'b1; load_n = 1'b0;
    @(posedge clk); #1;
    chk("R7", sw_on, 8'h01);
    m_sr = 8'h01; m_lat = 8'h01;

    // R8: load_n and ser_in toggling between edges leave ser_out alone
    shift_word(8'hB0, 1'b0);
    @(negedge clk);
    s = ser_out; held = sw_on;
    for (int i = 0; i < 4; i++) begin
      load_n = ~load_n; ser_in = ~ser_in;
      #0.4;
      chk("R8", {7'd0, ser_out}, {7'd0, s});
    end
    chk("R8", sw_on, held);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule